// File: doc/BRIEF.md
# Dual Threshold and Rate-of-Change Alarm

This block watches a bus of signed sample channels and raises up to two independent alarms. Each alarm picks one channel by code. It then compares either the sample level or the average change of that channel over a programmable number of samples against a signed threshold. A direction bit says whether the alarm fires above or below the threshold. One shared control bit chooses whether the comparisons use the filtered or the unfiltered copy of the sample bus. Both copies arrive as separate inputs and share a single update strobe.

Each alarm keeps a sticky flag. The flag sets on the sample that meets its condition and clears when the status read strobe pulses. A single alarm output is driven onto one of two lines, with its own enable and polarity. For the rate-of-change mode, the block keeps a short history of the selected channel. The mean of N successive differences equals (newest − Nth-older) / N, so the block compares that difference against threshold × N. No divider is needed.

Top module: `dual_alarm_monitor`

## Requirements
- R1: A 4-bit source code of 0 disables an alarm. Codes 1 to NCH (11) select channel code−1, which occupies bits [k*14+13 : k*14] of the sample bus. Codes above NCH also disable the alarm.
- R2: With `use_filt` = 1 both alarms read `filt_bus`. With `use_filt` = 0 they read `raw_bus`.
- R3: Bit 15 of a threshold word sets the direction: 1 fires when the value is strictly greater than the threshold, 0 when it is strictly less. Bits [13:0] hold a 14-bit two's-complement threshold. Bit 14 has no effect.
- R4: With the rate enable at 0, every cycle with `smp_valid` high compares the selected sample against the threshold. A hit sets the flag at that clock edge.
- R5: With the rate enable at 1, the value compared is y[n] − y[n−N] and the bound is threshold × N. N is the 8-bit window field, and a window of 0 behaves as 1.
- R6: A change of source, rate enable, window or filter choice restarts the history. The first rate comparison then happens on the (N+1)th sample after the restart, and no earlier sample sets the flag.
- R7: A set flag stays set, whatever the following samples show, until `stat_rd` is high at a clock edge.
- R8: `stat_rd` clears both flags at the next edge. If a sample in that same cycle meets an alarm's condition, that flag is 1 after the edge.
- R9: The alarm is active when `pin_en` = 1 and either flag is set. The active level equals `pin_pol`. `pin_line` = 0 drives `alarm_line1` and 1 drives `alarm_line2`. A line that is not selected or not active sits at the inverse of `pin_pol`.
- R10: Reset clears both flags and empties both histories.
- R11: The two alarms are independent: one alarm's configuration and samples never change the other alarm's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | New sample set present on the buses |
| raw_bus | input | NCH*DW | Unfiltered samples, channel k at [k*DW +: DW] |
| filt_bus | input | NCH*DW | Filtered samples, same layout |
| use_filt | input | 1 | 1 selects filtered data |
| a1_src | input | SEL_W | Alarm 1 source code |
| a1_roc | input | 1 | Alarm 1 rate-of-change enable |
| a1_thr | input | 16 | Alarm 1 threshold word |
| a1_win | input | WIN_W | Alarm 1 window length N |
| a2_src | input | SEL_W | Alarm 2 source code |
| a2_roc | input | 1 | Alarm 2 rate-of-change enable |
| a2_thr | input | 16 | Alarm 2 threshold word |
| a2_win | input | WIN_W | Alarm 2 window length N |
| stat_rd | input | 1 | Status read strobe, clears flags |
| pin_en | input | 1 | Alarm output enable |
| pin_pol | input | 1 | Active level of the alarm output |
| pin_line | input | 1 | 0 = line 1, 1 = line 2 |
| alarm_flag | output | 2 | Sticky flags, bit 0 alarm 1, bit 1 alarm 2 |
| alarm_line1 | output | 1 | Alarm output line 1 |
| alarm_line2 | output | 1 | Alarm output line 2 |

## Verification
A status read and a sample that meets an alarm's condition can land in the same clock cycle. The status read clears the flag, while the sample would set it. The bench raises `stat_rd` and `smp_valid` together with an alarm-level sample and expects the flag to be 1 after the edge. It repeats the same collision with a non-alarming sample and expects 0. This shows that a new event wins over the clear and is not lost, while a read with no new event still clears the flag.

// File: rtl/alm_pkg.sv
// Package: threshold word layout shared by the alarm blocks.
// Assumes a 16-bit threshold word with a direction bit and a 14-bit signed value.
package alm_pkg;
    localparam int THR_W     = 16;
    localparam int THR_DIR   = 15;
    localparam int THR_VAL_W = 14;

    // Direction decode: 1 = fire above threshold, 0 = fire below.
    function automatic logic thr_above(input logic [THR_W-1:0] w);
        return w[THR_DIR];
    endfunction

    // Signed threshold value held in the low bits.
    function automatic logic [THR_VAL_W-1:0] thr_value(input logic [THR_W-1:0] w);
        return w[THR_VAL_W-1:0];
    endfunction
endpackage

// File: rtl/alm_src_mux.sv
// Source mux: picks one DW-bit channel out of a flat bus by a 1-based code.
// Assumes code 0 and codes above NCH mean "no source"; sel_ok reports a legal code.
module alm_src_mux #(
    parameter int NCH   = 11,
    parameter int DW    = 14,
    parameter int SEL_W = 4
) (
    input  logic [NCH*DW-1:0] bus,
    input  logic [SEL_W-1:0]  code,
    output logic [DW-1:0]     word,
    output logic              sel_ok
);
    logic [DW-1:0] words [NCH];

    // Split the flat bus into channel words.
    for (genvar k = 0; k < NCH; k++) begin : g_split
        assign words[k] = bus[k*DW +: DW];
    end

    // Decode the code into a channel word and a legality flag.
    always_comb begin
        word   = '0;
        sel_ok = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            if (code == SEL_W'(k + 1)) begin
                word   = words[k];
                sel_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/alm_roc_hist.sv
// History ring: stores the last samples of one channel and serves the sample
// taken n_eff pushes ago. A fill counter tells when n_eff older samples exist.
// Assumes n_eff >= 1 and n_eff < 2**WIN_W, so the read slot never equals the write slot.
module alm_roc_hist #(
    parameter int DW    = 14,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             restart,
    input  logic [DW-1:0]    din,
    input  logic [WIN_W-1:0] n_eff,
    output logic             ready,
    output logic [DW-1:0]    old
);
    localparam int DEPTH = 1 << WIN_W;

    logic [DW-1:0]    mem [DEPTH];
    logic [WIN_W-1:0] wp;
    logic [WIN_W-1:0] cnt;
    logic [WIN_W-1:0] rd_idx;

    assign rd_idx = wp - n_eff;
    assign old    = mem[rd_idx];
    assign ready  = (cnt >= n_eff);

    // Sample storage: write the pushed sample at the write slot.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Write pointer and saturating fill count; a restart empties the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (push && restart)    cnt <= WIN_W'(1);
            else if (restart)       cnt <= '0;
            else if (push && cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    AST_FILL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt <= WIN_W'(1)));  // R6
    AST_FILL_EMPTY_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));  // R10
endmodule

// File: rtl/alm_cmp.sv
// Comparator: level or windowed-difference test against a signed threshold.
// In rate mode the bound is threshold * n_eff, so no division is needed.
// Assumes the product fits in CW bits (CW = DW + WIN_W + 2).
module alm_cmp #(
    parameter int DW    = 14,
    parameter int WIN_W = 8
) (
    input  logic [DW-1:0]    cur,
    input  logic [DW-1:0]    prev,
    input  logic             roc,
    input  logic [WIN_W-1:0] n_eff,
    input  logic             above,
    input  logic [DW-1:0]    thr,
    output logic             hit
);
    localparam int CW = DW + WIN_W + 2;

    logic signed [CW-1:0] cur_x, prev_x, thr_x, n_x, lhs, rhs;

    // Sign-extend operands, form both sides and compare in the chosen direction.
    always_comb begin
        cur_x  = {{(CW-DW){cur[DW-1]}}, cur};
        prev_x = {{(CW-DW){prev[DW-1]}}, prev};
        thr_x  = {{(CW-DW){thr[DW-1]}}, thr};
        n_x    = {{(CW-WIN_W){1'b0}}, n_eff};
        lhs    = roc ? (cur_x - prev_x) : cur_x;
        rhs    = roc ? (thr_x * n_x) : thr_x;
        hit    = above ? (lhs > rhs) : (lhs < rhs);
    end
endmodule

// File: rtl/alm_channel.sv
// One alarm channel: source pick, history, comparison and sticky flag.
// Assumes one shared filter choice; any configuration change restarts the history.
module alm_channel
    import alm_pkg::*;
#(
    parameter int NCH   = 11,
    parameter int DW    = 14,
    parameter int SEL_W = 4,
    parameter int WIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [NCH*DW-1:0] raw_bus,
    input  logic [NCH*DW-1:0] filt_bus,
    input  logic              use_filt,
    input  logic [SEL_W-1:0]  src,
    input  logic              roc,
    input  logic [THR_W-1:0]  thr,
    input  logic [WIN_W-1:0]  win,
    input  logic              stat_rd,
    output logic              flag
);
    localparam int CFG_W = SEL_W + WIN_W + 2;

    logic [NCH*DW-1:0] bus;
    logic [DW-1:0]     cur, prev;
    logic              sel_ok, ready, hit, restart, eval;
    logic [WIN_W-1:0]  n_eff;
    logic [CFG_W-1:0]  cfg, cfg_q;
    logic              thr_unused;

    assign thr_unused = thr[THR_VAL_W];
    assign bus     = use_filt ? filt_bus : raw_bus;
    assign n_eff   = (win == '0) ? WIN_W'(1) : win;
    assign cfg     = {src, roc, win, use_filt};
    assign restart = (cfg != cfg_q);

    alm_src_mux #(.NCH(NCH), .DW(DW), .SEL_W(SEL_W)) u_mux (
        .bus(bus), .code(src), .word(cur), .sel_ok(sel_ok)
    );

    alm_roc_hist #(.DW(DW), .WIN_W(WIN_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .push(smp_valid), .restart(restart),
        .din(cur), .n_eff(n_eff), .ready(ready), .old(prev)
    );

    alm_cmp #(.DW(DW), .WIN_W(WIN_W)) u_cmp (
        .cur(cur), .prev(prev), .roc(roc), .n_eff(n_eff),
        .above(thr_above(thr)), .thr(thr_value(thr)), .hit(hit)
    );

    assign eval = smp_valid && sel_ok && (!roc || (ready && !restart));

    // Configuration snapshot used to detect a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    // Sticky flag: a new hit wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag <= 1'b0;
        else if (eval && hit) flag <= 1'b1;
        else if (stat_rd)     flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_rd) |=> flag);  // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !smp_valid) |=> !flag);  // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == '0) && !flag) |=> !flag);  // R1
    AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (roc && restart && !flag) |=> !flag);  // R6
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !flag) |=> !flag);  // R4
endmodule

// File: rtl/alm_pin_drv.sv
// Output driver: merges both flags into one alarm and steers it to one of two lines.
// Assumes a disabled or unselected line rests at the inverse of the polarity.
module alm_pin_drv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] flags,
    input  logic       en,
    input  logic       pol,
    input  logic       line_sel,
    output logic       line1,
    output logic       line2
);
    logic active;

    // Alarm state and line levels.
    always_comb begin
        active = en && (|flags);
        line1  = (active && !line_sel) ? pol : !pol;
        line2  = (active &&  line_sel) ? pol : !pol;
    end

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !((line1 == pol) && (line2 == pol)));  // R9
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |-> ((line1 != pol) && (line2 != pol)));  // R9
endmodule

// File: rtl/dual_alarm_monitor.sv
// Top: two independent alarm channels over a shared sample bus and one alarm output.
// Assumes both buses change together and are qualified by smp_valid.
module dual_alarm_monitor
    import alm_pkg::*;
#(
    parameter int NCH   = 11,
    parameter int DW    = 14,
    parameter int SEL_W = 4,
    parameter int WIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [NCH*DW-1:0] raw_bus,
    input  logic [NCH*DW-1:0] filt_bus,
    input  logic              use_filt,
    input  logic [SEL_W-1:0]  a1_src,
    input  logic              a1_roc,
    input  logic [15:0]       a1_thr,
    input  logic [WIN_W-1:0]  a1_win,
    input  logic [SEL_W-1:0]  a2_src,
    input  logic              a2_roc,
    input  logic [15:0]       a2_thr,
    input  logic [WIN_W-1:0]  a2_win,
    input  logic              stat_rd,
    input  logic              pin_en,
    input  logic              pin_pol,
    input  logic              pin_line,
    output logic [1:0]        alarm_flag,
    output logic              alarm_line1,
    output logic              alarm_line2
);
    localparam int NALM = 2;

    logic [SEL_W-1:0] src_a [NALM];
    logic             roc_a [NALM];
    logic [THR_W-1:0] thr_a [NALM];
    logic [WIN_W-1:0] win_a [NALM];

    assign src_a[0] = a1_src;  assign src_a[1] = a2_src;
    assign roc_a[0] = a1_roc;  assign roc_a[1] = a2_roc;
    assign thr_a[0] = a1_thr;  assign thr_a[1] = a2_thr;
    assign win_a[0] = a1_win;  assign win_a[1] = a2_win;

    for (genvar g = 0; g < NALM; g++) begin : g_alm
        alm_channel #(.NCH(NCH), .DW(DW), .SEL_W(SEL_W), .WIN_W(WIN_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
            .raw_bus(raw_bus), .filt_bus(filt_bus), .use_filt(use_filt),
            .src(src_a[g]), .roc(roc_a[g]), .thr(thr_a[g]), .win(win_a[g]),
            .stat_rd(stat_rd), .flag(alarm_flag[g])
        );
    end

    alm_pin_drv u_pin (
        .clk(clk), .rst_n(rst_n), .flags(alarm_flag), .en(pin_en),
        .pol(pin_pol), .line_sel(pin_line),
        .line1(alarm_line1), .line2(alarm_line2)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (alarm_flag == 2'b00));  // R10
endmodule

// File: tb/tb_dual_alarm_monitor.sv
module tb_dual_alarm_monitor;
    localparam int CLK_T = 10;
    localparam int NCH = 11;
    localparam int DW  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [NCH*DW-1:0] raw_bus = '0, filt_bus = '0;
    logic use_filt = 1'b0;
    logic [3:0] a1_src = '0, a2_src = '0;
    logic a1_roc = 1'b0, a2_roc = 1'b0;
    logic [15:0] a1_thr = '0, a2_thr = '0;
    logic [7:0] a1_win = '0, a2_win = '0;
    logic stat_rd = 1'b0;
    logic pin_en = 1'b1, pin_pol = 1'b1, pin_line = 1'b0;
    logic [1:0] alarm_flag;
    logic alarm_line1, alarm_line2;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    dual_alarm_monitor dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .raw_bus(raw_bus), .filt_bus(filt_bus), .use_filt(use_filt),
        .a1_src(a1_src), .a1_roc(a1_roc), .a1_thr(a1_thr), .a1_win(a1_win),
        .a2_src(a2_src), .a2_roc(a2_roc), .a2_thr(a2_thr), .a2_win(a2_win),
        .stat_rd(stat_rd), .pin_en(pin_en), .pin_pol(pin_pol), .pin_line(pin_line),
        .alarm_flag(alarm_flag), .alarm_line1(alarm_line1), .alarm_line2(alarm_line2)
    );

    typedef struct packed {
        logic [3:0]  src;
        logic [15:0] thr;
        logic [13:0] sel_v;
        logic [13:0] oth_v;
        logic [13:0] flt_v;
        logic        fsel;
        logic        exp;
    } vec_t;

    // Static-mode vectors for alarm 1: source, threshold word, selected raw value,
    // value on all other channels, selected filtered value, filter choice, expected flag.
    localparam vec_t VECS [0:11] = '{
        '{4'd1,  16'h8064, 14'd150,    14'd0,    14'd0,   1'b0, 1'b1},
        '{4'd1,  16'h8064, 14'd100,    14'd0,    14'd0,   1'b0, 1'b0},
        '{4'd1,  16'h8064, 14'd101,    14'd0,    14'd0,   1'b0, 1'b1},
        '{4'd3,  16'h0064, 14'd99,     14'd500,  14'd0,   1'b0, 1'b1},
        '{4'd3,  16'h0064, 14'd200,    14'd0,    14'd0,   1'b0, 1'b0},
        '{4'd11, 16'hBFCE, 14'h3FF6,   14'h3FC4, 14'd0,   1'b0, 1'b1},
        '{4'd11, 16'hBFCE, 14'h3FC4,   14'd0,    14'd0,   1'b0, 1'b0},
        '{4'd0,  16'h8000, 14'd1000,   14'd1000, 14'd0,   1'b0, 1'b0},
        '{4'd12, 16'h8000, 14'd1000,   14'd1000, 14'd0,   1'b0, 1'b0},
        '{4'd2,  16'h8064, 14'd0,      14'd0,    14'd500, 1'b1, 1'b1},
        '{4'd2,  16'h8064, 14'd500,    14'd0,    14'd0,   1'b1, 1'b0},
        '{4'd1,  16'hC064, 14'd150,    14'd0,    14'd0,   1'b0, 1'b1}
    };

    task automatic check(input logic got, input logic exp, input string what);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic set_bus(input int idx, input logic [13:0] sv,
                           input logic [13:0] ov, input logic [13:0] fv);
        for (int k = 0; k < NCH; k++) begin
            raw_bus[k*DW +: DW]  = (k == idx) ? sv : ov;
            filt_bus[k*DW +: DW] = (k == idx) ? fv : ov;
        end
    endtask

    task automatic set_all(input logic [13:0] v);
        set_bus(-1, v, v, v);
    endtask

    // One sample cycle, optionally with a status read in the same cycle.
    task automatic push(input logic rd);
        @(negedge clk);
        smp_valid = 1'b1;
        stat_rd   = rd;
        @(negedge clk);
        smp_valid = 1'b0;
        stat_rd   = 1'b0;
    endtask

    task automatic push_all(input logic [13:0] v);
        @(negedge clk);
        set_all(v);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(alarm_flag[0], 1'b0, "R10 flag1 after reset");
        check(alarm_flag[1], 1'b0, "R10 flag2 after reset");
        check(alarm_line1, 1'b0, "R9 line1 idle after reset");
        check(alarm_line2, 1'b0, "R9 line2 idle after reset");

        // Table walk: R1 R2 R3 R4 on alarm 1 static comparisons
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            a1_src   = VECS[i].src;
            a1_thr   = VECS[i].thr;
            use_filt = VECS[i].fsel;
            set_bus(int'(VECS[i].src) - 1, VECS[i].sel_v, VECS[i].oth_v, VECS[i].flt_v);
            clear_flags();
            push(1'b0);
            check(alarm_flag[0], VECS[i].exp, $sformatf("R1/R2/R3/R4 vector %0d", i));
        end
        use_filt = 1'b0;

        // R7 and R8: sticky flag, read clear, collision with a sample
        a1_src = 4'd1;
        a1_thr = 16'h8064;
        clear_flags();
        set_bus(0, 14'd150, 14'd0, 14'd0);
        push(1'b0);
        check(alarm_flag[0], 1'b1, "R4 hit sets flag");
        set_bus(0, 14'd50, 14'd0, 14'd0);
        push(1'b0);
        check(alarm_flag[0], 1'b1, "R7 flag held after quiet sample");
        clear_flags();
        check(alarm_flag[0], 1'b0, "R8 read clears flag");
        set_bus(0, 14'd150, 14'd0, 14'd0);
        push(1'b1);
        check(alarm_flag[0], 1'b1, "R8 hit wins over same-cycle read");
        set_bus(0, 14'd50, 14'd0, 14'd0);
        push(1'b1);
        check(alarm_flag[0], 1'b0, "R8 read with quiet sample clears");

        // R9: output steering and polarity
        set_bus(0, 14'd150, 14'd0, 14'd0);
        push(1'b0);
        #1;
        check(alarm_line1, 1'b1, "R9 line1 active high");
        check(alarm_line2, 1'b0, "R9 line2 idle");
        pin_line = 1'b1; #1;
        check(alarm_line1, 1'b0, "R9 line1 idle after switch");
        check(alarm_line2, 1'b1, "R9 line2 active high");
        pin_pol = 1'b0; #1;
        check(alarm_line2, 1'b0, "R9 line2 active low");
        check(alarm_line1, 1'b1, "R9 line1 rests high");
        pin_en = 1'b0; #1;
        check(alarm_line2, 1'b1, "R9 disabled line2 inactive");
        pin_en = 1'b1; pin_pol = 1'b1; pin_line = 1'b0;
        clear_flags();
        #1;
        check(alarm_line1, 1'b0, "R9 line1 idle after clear");

        // R5 R6 R11: rate mode on alarm 2, window 3, threshold +10 above
        @(negedge clk);
        a1_src = 4'd0;
        a2_src = 4'd5; a2_roc = 1'b1; a2_win = 8'd3; a2_thr = 16'h800A;
        clear_flags();
        push_all(14'd0);
        push_all(14'd20);
        push_all(14'd40);
        check(alarm_flag[1], 1'b0, "R6 no result during warm-up");
        push_all(14'd60);
        check(alarm_flag[1], 1'b1, "R5 diff 60 above 30");
        check(alarm_flag[0], 1'b0, "R11 alarm 1 untouched");
        a2_src = 4'd6;
        clear_flags();
        push_all(14'd0);
        push_all(14'd10);
        push_all(14'd20);
        push_all(14'd30);
        check(alarm_flag[1], 1'b0, "R5 diff 30 equal to bound");
        push_all(14'd41);
        check(alarm_flag[1], 1'b1, "R5 diff 31 above bound");

        // R5: window 0 acts as 1, below direction, threshold -5
        a2_win = 8'd0; a2_thr = 16'h3FFB;
        clear_flags();
        push_all(14'd100);
        check(alarm_flag[1], 1'b0, "R6 first sample after restart");
        push_all(14'd94);
        check(alarm_flag[1], 1'b1, "R5 window 0 diff -6 below -5");

        // R10: reset mid-run clears flags and history
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(alarm_flag[1], 1'b0, "R10 flag2 cleared by reset");
        @(negedge clk);
        push_all(14'd0);
        check(alarm_flag[1], 1'b0, "R10 history empty after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule